// File: doc/BRIEF.md
# Two-Tier Clock Gear Controller

This block turns one source clock into two families of clock-enable strobes. A high-speed strobe fires once every 1, 2, 4, 8 or 16 source cycles, as a 3-bit gear code selects. A middle-speed strobe fires once every 1, 2 or 4 high-speed strobes, as a 2-bit code selects. Logic that runs in either domain advances only on the cycles where its strobe is high.

Software requests new ratios with a one-cycle write of both codes. Each request is held as a target and is not applied at once. The gear target is taken over at the next wrap of the high-speed divider. The middle-speed target is taken over at the next cycle where both dividers wrap together, so no strobe period is ever cut short. A status output always shows the ratios in force. A busy flag is high while any target differs from its applied ratio, and transfers between the two domains are held off during that time. Codes that name no ratio are dropped field by field, and a later request replaces one that has not yet been applied.

Top module: `gear_clock_ctrl`

## Requirements
- R1: After reset both applied codes read 0, busy is low, and both strobes are high in every source cycle.
- R2: With gear code g (0 to 4) applied, the high-speed strobe is high exactly once every 2^g source cycles.
- R3: With gear code g and middle code m (0 = /1, 1 = /2, 2 = /4) applied, the middle-speed strobe is high exactly once every 2^g * 2^m source cycles, and only in cycles where the high-speed strobe is also high.
- R4: From the first cycle after a write whose legal code differs from the applied one, busy is high and the status still shows the old code, until that field is applied.
- R5: A new gear code is applied at a high-speed divider wrap, and busy falls no more than 2^g + 1 cycles after the write, where g is the old gear code (at most 17).
- R6: A new middle code is applied only where both dividers wrap, and busy falls no more than 2^g * 2^m + 1 cycles after the write, where m is the old middle code.
- R7: Gear codes 5 to 7 and middle code 3 are ignored field by field: they leave the target, the status, busy and the strobe rate unchanged, while the other field of the same write still takes effect.
- R8: A write that arrives while an earlier request is still pending replaces it. Busy stays high, the status never shows the replaced value, and only the last value is applied.
- R9: The status outputs equal the applied gear and middle codes, and they do not change in any cycle that follows a cycle in which busy was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (fc) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for both code fields |
| wr_gear | input | 3 | Requested gear code, ratio 1/2^code |
| wr_mid | input | 2 | Requested middle-speed code, ratio 1/2^code |
| hs_en | output | 1 | High-speed clock-enable strobe |
| ms_en | output | 1 | Middle-speed clock-enable strobe |
| busy | output | 1 | Ratio change in progress, hold cross-domain transfers |
| stat_gear | output | 3 | Applied gear code |
| stat_mid | output | 2 | Applied middle-speed code |

## Verification
Busy reflects a write one source cycle after the write cycle, because the target is registered at that edge. An apply moves the status and clears busy one cycle after the matching divider wrap. The strobes are decoded straight from the divider state, so they have no latency of their own. The bench drives and samples on falling edges. It counts falling edges from the write until busy drops and compares that count against the ratio-dependent bounds of R5 and R6. It measures strobe periods only once busy is low. For the replacement case it lines up the first write with a wrap, so that the second write lands before the next possible apply.

// File: rtl/gear_pkg.sv
package gear_pkg;

   // counter width for a divider whose largest log2 ratio is max_code
   function automatic int cnt_width(input int max_code);
      return (max_code > 0) ? max_code : 1;
   endfunction

endpackage

// File: rtl/gear_div.sv
module gear_div #(
   parameter int CODE_W = 3,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              wrap
);

   localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_w
      $error("gear_div: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;

   // terminal count 2^code - 1, saturating at all ones
   assign term = ~(ONES << code);
   assign wrap = tick && (cnt == term);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick)
         cnt <= wrap ? '0 : cnt + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term); // R2

endmodule

// File: rtl/ratio_shadow.sv
module ratio_shadow #(
   parameter int W   = 3,
   parameter int MAX = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_code,
   input  logic         boundary,
   output logic [W-1:0] active,
   output logic         pending
);

   localparam logic [W-1:0] MAX_C = W'(MAX);

   if (MAX >= (1 << W)) begin : g_bad_max
      $error("ratio_shadow: MAX does not fit in W bits");
   end

   logic         code_ok;
   logic [W-1:0] target;

   // every code legal: no range compare needed
   if (MAX == (1 << W) - 1) begin : g_all_legal
      assign code_ok = 1'b1;
   end else begin : g_range_chk
      assign code_ok = (wr_code <= MAX_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target <= '0;
         active <= '0;
      end else begin
         if (wr_en && code_ok)
            target <= wr_code;
         if (boundary)
            active <= target;
      end
   end

   assign pending = (target != active);

   AST_APPLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(active)); // R5 R6
   AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      target <= MAX_C); // R7

endmodule

// File: rtl/gear_clock_ctrl.sv
module gear_clock_ctrl
   import gear_pkg::*;
#(
   parameter int GEAR_W   = 3,
   parameter int MID_W    = 2,
   parameter int GEAR_MAX = 4,
   parameter int MID_MAX  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GEAR_W-1:0] wr_gear,
   input  logic [MID_W-1:0]  wr_mid,
   output logic              hs_en,
   output logic              ms_en,
   output logic              busy,
   output logic [GEAR_W-1:0] stat_gear,
   output logic [MID_W-1:0]  stat_mid
);

   localparam int HS_CW = cnt_width(GEAR_MAX);
   localparam int MS_CW = cnt_width(MID_MAX);
   localparam logic [GEAR_W-1:0] GEAR_MAX_C = GEAR_W'(GEAR_MAX);
   localparam logic [MID_W-1:0]  MID_MAX_C  = MID_W'(MID_MAX);

   if (GEAR_MAX < 0 || MID_MAX < 0) begin : g_bad_max
      $error("gear_clock_ctrl: maximum codes must not be negative");
   end

   logic pend_gear;
   logic pend_mid;

   ratio_shadow #(.W(GEAR_W), .MAX(GEAR_MAX)) u_gear_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_code  (wr_gear),
      .boundary (hs_en),
      .active   (stat_gear),
      .pending  (pend_gear)
   );

   ratio_shadow #(.W(MID_W), .MAX(MID_MAX)) u_mid_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_code  (wr_mid),
      .boundary (ms_en),
      .active   (stat_mid),
      .pending  (pend_mid)
   );

   // high-speed divider runs on every source cycle
   gear_div #(.CODE_W(GEAR_W), .CNT_W(HS_CW)) u_hs_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (1'b1),
      .code  (stat_gear),
      .wrap  (hs_en)
   );

   // middle-speed divider counts high-speed strobes
   gear_div #(.CODE_W(MID_W), .CNT_W(MS_CW)) u_ms_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (hs_en),
      .code  (stat_mid),
      .wrap  (ms_en)
   );

   assign busy = pend_gear | pend_mid;

   AST_MS_INSIDE_HS: assert property (@(posedge clk) disable iff (!rst_n)
      ms_en |-> hs_en); // R3
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable({stat_gear, stat_mid})); // R9
   AST_BAD_CODES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && wr_gear > GEAR_MAX_C && wr_mid > MID_MAX_C) |=> !busy); // R7
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      stat_gear <= GEAR_MAX_C && stat_mid <= MID_MAX_C); // R9

endmodule

// File: tb/gear_clock_ctrl_tb.sv
`timescale 1ns/1ps
module gear_clock_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_gear = '0;
   logic [1:0] wr_mid = '0;
   logic       hs_en, ms_en, busy;
   logic [2:0] stat_gear;
   logic [1:0] stat_mid;

   int checks = 0;
   int errors = 0;
   int cur_g = 0;
   int cur_m = 0;

   always #5 clk = ~clk;

   gear_clock_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_gear   (wr_gear),
      .wr_mid    (wr_mid),
      .hs_en     (hs_en),
      .ms_en     (ms_en),
      .busy      (busy),
      .stat_gear (stat_gear),
      .stat_mid  (stat_mid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_write(input int g, input int m);
      wr_en = 1'b1;
      wr_gear = 3'(g);
      wr_mid = 2'(m);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int cycles);
      cycles = 1;
      while (busy && cycles < 300) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic measure(input bit use_ms, output int period, output int stray);
      int k = 0;
      stray = 0;
      while (!(use_ms ? ms_en : hs_en) && k < 300) begin
         @(negedge clk);
         k++;
      end
      period = 0;
      do begin
         @(negedge clk);
         period++;
         if (ms_en && !hs_en) stray++;
      end while (!(use_ms ? ms_en : hs_en) && period < 300);
   endtask

   task automatic t_reset();
      chk(stat_gear == 0, "R1 gear status", stat_gear, 0);
      chk(stat_mid == 0, "R1 mid status", stat_mid, 0);
      chk(busy == 0, "R1 busy", busy, 0);
      chk(hs_en && ms_en, "R1 strobes", {hs_en, ms_en}, 3);
      @(negedge clk);
      chk(hs_en && ms_en, "R1 strobes next cycle", {hs_en, ms_en}, 3);
   endtask

   task automatic t_gear(input int g);
      int cyc, per, stray;
      do_write(g, cur_m);
      chk(busy == (g != cur_g), "R4 busy after gear write", busy, g != cur_g);
      if (g != cur_g) chk(stat_gear == cur_g, "R4 old gear shown", stat_gear, cur_g);
      wait_idle(cyc);
      chk(cyc <= (1 << cur_g) + 1, "R5 gear switch latency", cyc, (1 << cur_g) + 1);
      cur_g = g;
      chk(stat_gear == g, "R9 gear status", stat_gear, g);
      measure(1'b0, per, stray);
      chk(per == (1 << g), "R2 hs period", per, 1 << g);
      measure(1'b1, per, stray);
      chk(per == ((1 << g) << cur_m), "R3 ms period", per, (1 << g) << cur_m);
      chk(stray == 0, "R3 ms only with hs", stray, 0);
   endtask

   task automatic t_mid(input int m);
      int cyc, per, stray;
      do_write(cur_g, m);
      chk(busy == (m != cur_m), "R4 busy after mid write", busy, m != cur_m);
      wait_idle(cyc);
      chk(cyc <= ((1 << cur_g) << cur_m) + 1, "R6 mid switch latency", cyc,
          ((1 << cur_g) << cur_m) + 1);
      cur_m = m;
      chk(stat_mid == m, "R9 mid status", stat_mid, m);
      measure(1'b1, per, stray);
      chk(per == ((1 << cur_g) << m), "R3 ms period after mid change", per, (1 << cur_g) << m);
      chk(stray == 0, "R3 ms only with hs", stray, 0);
   endtask

   task automatic t_replace();
      int cyc, per, stray;
      while (!hs_en) @(negedge clk);
      do_write(1, cur_m);
      chk(busy == 1, "R8 busy after first write", busy, 1);
      do_write(2, cur_m);
      chk(busy == 1, "R8 busy after second write", busy, 1);
      chk(stat_gear == cur_g, "R8 old gear still applied", stat_gear, cur_g);
      wait_idle(cyc);
      cur_g = 2;
      chk(stat_gear == 2, "R8 last request applied", stat_gear, 2);
      measure(1'b0, per, stray);
      chk(per == 4, "R8 hs period after replace", per, 4);
   endtask

   task automatic t_invalid();
      int cyc, per, stray;
      do_write(6, 3);
      chk(busy == 0, "R7 no busy on bad codes", busy, 0);
      chk(stat_gear == cur_g, "R7 gear kept", stat_gear, cur_g);
      chk(stat_mid == cur_m, "R7 mid kept", stat_mid, cur_m);
      measure(1'b0, per, stray);
      chk(per == (1 << cur_g), "R7 hs period unchanged", per, 1 << cur_g);
      do_write(7, 1);
      chk(busy == (cur_m != 1), "R7 legal mid field still taken", busy, cur_m != 1);
      wait_idle(cyc);
      chk(stat_gear == cur_g, "R7 gear kept with bad gear code", stat_gear, cur_g);
      chk(stat_mid == 1, "R7 mid applied beside bad gear", stat_mid, 1);
      cur_m = 1;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gear(1);
      t_gear(3);
      t_gear(4);
      t_gear(0);
      t_gear(4);
      t_replace();
      t_mid(1);
      t_mid(2);
      t_invalid();
      t_mid(0);
      t_gear(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule